// File: doc/BRIEF.md
# Virtual Processor Run-Gate Controller

This block decides which of several hardware threads (virtual processors, VPs) may run. Each VP owns a one-bit control register, the "exclusive" bit. A VP that sets its own bit keeps running. Every other VP is gated off while that bit is set. The block serves the two instructions that act on this bit: a disable request (claim exclusivity) and an enable request (release it). It reports back the control-register value as it stood before the request. It also emits one-cycle sleep and wake pulses towards the other VPs.

The block derives a run-permit per VP and a has-work flag per VP from the exclusive bits, the halted (waiting for interrupt) status and a pending-wake input. It also answers coprocessor accesses to two per-VP registers: the control register and a read-only global-number register holding the VP's identifier. A configuration input says whether the feature is present. When the feature is absent, requests are dropped and register accesses are reported as unimplemented. Requests from several VPs in one cycle are served one at a time, lowest VP index first.

Top module: `vp_run_gate`

## Requirements
- R1: After reset every exclusive bit is clear, so all VPs are active. `done_o`, `sleep_o` and `wake_o` are zero. A control-register read returns 0. The exclusive bit is bit 0 and all other bits read as zero.
- R2: A granted disable request from VP k whose bit is clear has these effects in the cycle after the request: `done_o[k]` pulses, `prev_o` is 0, `sleep_o` pulses for every VP except k, and bit k is set.
- R3: A granted disable request from VP k whose bit is already set returns `prev_o` = 1. It leaves every bit unchanged and produces no sleep or wake pulse.
- R4: A granted enable request from VP k whose bit is set returns `prev_o` = 1 and clears bit k. It pulses `wake_o` for every VP other than k, except a VP that was halted and active in the request cycle.
- R5: A granted enable request from VP k whose bit is clear returns `prev_o` = 0 and changes nothing else.
- R6: `active_o[i]` is 1 when bit i is set, or when no other VP has its bit set. When the feature flag is clear, all VPs are active.
- R7: `has_work_o[i]` equals `active_o[i]` AND (NOT `halted_i[i]` OR `wake_pend_i[i]`). An inactive VP never has work.
- R8: The global-number register of VP i reads as (i AND 0xFF) in bits 7:0, and zero above. The value is loaded at reset.
- R9: Coprocessor writes change neither register. A read returns the current value the same cycle. `cop_sel_i` = 0 selects the control register and 1 selects the global number.
- R10: While `vp_present_i` is 0, requests produce no grant, no busy, no done and no change. Any coprocessor access raises `cop_unimpl_o` and reads 0.
- R11: Among simultaneous requesters the lowest-indexed VP is granted. The others see `busy_o` in that cycle and must retry. A VP asserting both requests at once is treated as disabling.
- R12: At most one request is granted per cycle, so `done_o` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vp_present_i | input | 1 | Feature-present configuration flag |
| dis_req_i | input | NUM_VP | Disable (claim exclusivity) request per VP |
| en_req_i | input | NUM_VP | Enable (release) request per VP |
| halted_i | input | NUM_VP | VP is halted waiting for an interrupt |
| wake_pend_i | input | NUM_VP | Pending wake event per VP |
| busy_o | output | NUM_VP | Request refused this cycle, retry |
| done_o | output | NUM_VP | Request served (one cycle after the request) |
| prev_o | output | DATA_W | Previous control-register value of the served VP |
| sleep_o | output | NUM_VP | Put-to-sleep pulse per VP |
| wake_o | output | NUM_VP | Wake pulse per VP |
| active_o | output | NUM_VP | Run permit per VP |
| has_work_o | output | NUM_VP | VP is eligible to execute |
| cop_rd_i | input | 1 | Coprocessor register read strobe |
| cop_wr_i | input | 1 | Coprocessor register write strobe |
| cop_vp_i | input | VP_W | VP whose register is accessed |
| cop_sel_i | input | 1 | 0 = control register, 1 = global number |
| cop_rdata_o | output | DATA_W | Read data |
| cop_unimpl_o | output | 1 | Access to an unimplemented register |

## Verification
The assertions assume that a request stays a plain level sampled at each rising edge. A refused requester simply asserts again later. They also assume the halted status and the feature flag change only between edges. The bench drives every input on the falling edge and holds it for exactly one cycle per step, so each request is seen once. It changes the feature flag only while no request is pending. Halted-while-active cases are built deliberately, with two VPs holding their bits, so that the wake exclusion is exercised under the same input discipline.

// File: rtl/vp_gate_pkg.sv
package vp_gate_pkg;
  localparam int MAXV = 64;

  typedef enum logic { SEL_CTRL = 1'b0, SEL_GNUM = 1'b1 } cop_sel_e;

  // Run permit: own bit set, or no other VP holds its bit.
  function automatic logic [MAXV-1:0] active_mask(input logic [MAXV-1:0] bits);
    logic [MAXV-1:0] res;
    for (int i = 0; i < MAXV; i++) begin
      res[i] = bits[i] | ~|(bits & ~(MAXV'(1) << i));
    end
    return res;
  endfunction

  // Isolate the lowest set bit.
  function automatic logic [MAXV-1:0] lowest_one(input logic [MAXV-1:0] v);
    return v & (~v + MAXV'(1));
  endfunction

  // Identifier field of the global-number register.
  function automatic logic [7:0] vp_ident(input int idx);
    return 8'(idx & 8'hFF);
  endfunction
endpackage

// File: rtl/vp_gate_arb.sv
module vp_gate_arb
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4
) (
  input  logic [NUM_VP-1:0] req_i,
  output logic [NUM_VP-1:0] grant_o,
  output logic [NUM_VP-1:0] busy_o
);
  logic [MAXV-1:0] low_full;

  always_comb begin
    low_full = lowest_one(MAXV'(req_i));
    grant_o  = low_full[NUM_VP-1:0];
    busy_o   = req_i & ~grant_o;
  end
endmodule

// File: rtl/vp_gate_ctl.sv
module vp_gate_ctl
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic [NUM_VP-1:0] dis_req_i,
  input  logic [NUM_VP-1:0] en_req_i,
  input  logic [NUM_VP-1:0] halted_i,
  output logic [NUM_VP-1:0] busy_o,
  output logic [NUM_VP-1:0] dis_bits_o,
  output logic [NUM_VP-1:0] active_o,
  output logic [NUM_VP-1:0] done_o,
  output logic              prev_bit_o,
  output logic [NUM_VP-1:0] sleep_o,
  output logic [NUM_VP-1:0] wake_o
);
  logic [NUM_VP-1:0] req, grant, bits_q, bits_d;
  logic [NUM_VP-1:0] sleep_d, wake_d;
  logic [MAXV-1:0]   act_full;
  logic              sel_bit, sel_dis;

  assign req = present_i ? (dis_req_i | en_req_i) : '0;

  vp_gate_arb #(.NUM_VP(NUM_VP)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .busy_o  (busy_o)
  );

  always_comb begin
    act_full = active_mask(MAXV'(bits_q));
    active_o = present_i ? act_full[NUM_VP-1:0] : '1;
    sel_bit  = |(grant & bits_q);
    sel_dis  = |(grant & dis_req_i);
    bits_d   = bits_q;
    sleep_d  = '0;
    wake_d   = '0;
    if (|grant) begin
      if (sel_dis && !sel_bit) begin
        sleep_d = ~grant;
        bits_d  = bits_q | grant;
      end else if (!sel_dis && sel_bit) begin
        wake_d  = ~grant & ~(halted_i & active_o);
        bits_d  = bits_q & ~grant;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q     <= '0;
      done_o     <= '0;
      prev_bit_o <= 1'b0;
      sleep_o    <= '0;
      wake_o     <= '0;
    end else begin
      bits_q     <= bits_d;
      done_o     <= grant;
      prev_bit_o <= |grant & sel_bit;
      sleep_o    <= sleep_d;
      wake_o     <= wake_d;
    end
  end

  assign dis_bits_o = bits_q;
endmodule

// File: rtl/vp_gate_cop.sv
module vp_gate_cop
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int VP_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [VP_W-1:0]   vp_i,
  input  cop_sel_e          sel_i,
  input  logic [NUM_VP-1:0] dis_bits_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unimpl_o
);
  logic [7:0] gnum_q [NUM_VP];

  // Identifier registers: loaded at reset, never written afterwards.
  for (genvar g = 0; g < NUM_VP; g++) begin : g_gnum
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnum_q[g] <= vp_ident(g);
      else        gnum_q[g] <= gnum_q[g];
    end
  end

  always_comb begin
    unimpl_o = !present_i && (rd_i || wr_i);
    rdata_o  = '0;
    if (present_i && rd_i) begin
      if (sel_i == SEL_GNUM) rdata_o = DATA_W'(gnum_q[vp_i]);
      else                   rdata_o = DATA_W'(dis_bits_i[vp_i]);
    end
  end
endmodule

// File: rtl/vp_run_gate.sv
module vp_run_gate
  import vp_gate_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int DATA_W = 32,
  localparam int VP_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vp_present_i,
  input  logic [NUM_VP-1:0] dis_req_i,
  input  logic [NUM_VP-1:0] en_req_i,
  input  logic [NUM_VP-1:0] halted_i,
  input  logic [NUM_VP-1:0] wake_pend_i,
  output logic [NUM_VP-1:0] busy_o,
  output logic [NUM_VP-1:0] done_o,
  output logic [DATA_W-1:0] prev_o,
  output logic [NUM_VP-1:0] sleep_o,
  output logic [NUM_VP-1:0] wake_o,
  output logic [NUM_VP-1:0] active_o,
  output logic [NUM_VP-1:0] has_work_o,
  input  logic              cop_rd_i,
  input  logic              cop_wr_i,
  input  logic [VP_W-1:0]   cop_vp_i,
  input  logic              cop_sel_i,
  output logic [DATA_W-1:0] cop_rdata_o,
  output logic              cop_unimpl_o
);
  logic [NUM_VP-1:0] dis_bits;
  logic              prev_bit;

  vp_gate_ctl #(.NUM_VP(NUM_VP)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .present_i  (vp_present_i),
    .dis_req_i  (dis_req_i),
    .en_req_i   (en_req_i),
    .halted_i   (halted_i),
    .busy_o     (busy_o),
    .dis_bits_o (dis_bits),
    .active_o   (active_o),
    .done_o     (done_o),
    .prev_bit_o (prev_bit),
    .sleep_o    (sleep_o),
    .wake_o     (wake_o)
  );

  vp_gate_cop #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_cop (
    .clk        (clk),
    .rst_n      (rst_n),
    .present_i  (vp_present_i),
    .rd_i       (cop_rd_i),
    .wr_i       (cop_wr_i),
    .vp_i       (cop_vp_i),
    .sel_i      (cop_sel_e'(cop_sel_i)),
    .dis_bits_i (dis_bits),
    .rdata_o    (cop_rdata_o),
    .unimpl_o   (cop_unimpl_o)
  );

  assign prev_o     = DATA_W'(prev_bit);
  assign has_work_o = active_o & (~halted_i | wake_pend_i);
endmodule

// File: rtl/vp_gate_chk.sv
module vp_gate_chk #(
  parameter int NUM_VP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vp_present_i,
  input logic [NUM_VP-1:0] dis_req_i,
  input logic [NUM_VP-1:0] en_req_i,
  input logic [NUM_VP-1:0] halted_i,
  input logic [NUM_VP-1:0] busy_o,
  input logic [NUM_VP-1:0] done_o,
  input logic [NUM_VP-1:0] sleep_o,
  input logic [NUM_VP-1:0] wake_o,
  input logic [NUM_VP-1:0] active_o,
  input logic [NUM_VP-1:0] has_work_o,
  input logic [NUM_VP-1:0] dis_bits
);
  assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  assert_sleep_wake_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|sleep_o && |wake_o));

  assert_absent_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vp_present_i |=> (done_o == '0));

  assert_own_bit_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vp_present_i |-> ((active_o & dis_bits) == dis_bits));

  assert_work_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (has_work_o & ~active_o) == '0);

  assert_busy_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o & ~(dis_req_i | en_req_i)) == '0);

  assert_wake_spares_waiters_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |done_o |-> ((wake_o & $past(halted_i & active_o)) == '0));
endmodule

bind vp_run_gate vp_gate_chk #(.NUM_VP(NUM_VP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vp_present_i (vp_present_i),
  .dis_req_i    (dis_req_i),
  .en_req_i     (en_req_i),
  .halted_i     (halted_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .sleep_o      (sleep_o),
  .wake_o       (wake_o),
  .active_o     (active_o),
  .has_work_o   (has_work_o),
  .dis_bits     (dis_bits)
);

// File: tb/tb_vp_run_gate.sv
module tb_vp_run_gate;
  localparam int N = 4;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, present = 1;
  logic [N-1:0] dis, en, halt, wpend;
  logic [N-1:0] busy, done, sleep, wake, act, work;
  logic [DW-1:0] prev, rdata;
  logic crd, cwr, csel, unimpl;
  logic [1:0] cvp;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vp_run_gate #(.NUM_VP(N), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .vp_present_i(present),
    .dis_req_i(dis), .en_req_i(en), .halted_i(halt), .wake_pend_i(wpend),
    .busy_o(busy), .done_o(done), .prev_o(prev), .sleep_o(sleep),
    .wake_o(wake), .active_o(act), .has_work_o(work),
    .cop_rd_i(crd), .cop_wr_i(cwr), .cop_vp_i(cvp), .cop_sel_i(csel),
    .cop_rdata_o(rdata), .cop_unimpl_o(unimpl)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Fields: dis en halt busy done prev sleep wake active (33 bits)
  localparam logic [32:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0, 4'b1110, 4'b0000, 4'b0001}, // R2
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b1, 4'b0000, 4'b0000, 4'b0001}, // R3
    {4'b0000, 4'b0001, 4'b0100, 4'b0000, 4'b0001, 1'b1, 4'b0000, 4'b1110, 4'b1111}, // R4
    {4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 1'b0, 4'b0000, 4'b0000, 4'b1111}, // R5
    {4'b0110, 4'b0000, 4'b0000, 4'b0100, 4'b0010, 1'b0, 4'b1101, 4'b0000, 4'b0010}, // R11
    {4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0, 4'b1011, 4'b0000, 4'b0110}, // R6
    {4'b0000, 4'b0010, 4'b0100, 4'b0000, 4'b0010, 1'b1, 4'b0000, 4'b1001, 4'b0100}, // R4
    {4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0100, 1'b1, 4'b0000, 4'b1011, 4'b1111}  // R4
  };

  task automatic step(input logic [N-1:0] d, input logic [N-1:0] e, input logic [N-1:0] h);
    @(negedge clk);
    dis = d; en = e; halt = h;
    @(negedge clk);
    dis = '0; en = '0;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dis = '0; en = '0; halt = '0; wpend = '0;
    crd = 0; cwr = 0; csel = 0; cvp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", DW'(act), DW'(4'b1111));
    chk("R1 done", DW'(done | sleep | wake), 0);
    crd = 1; csel = 0; cvp = 2'd3; #1;
    chk("R1 ctrl read", rdata, 0);
    // R8 global numbers
    csel = 1;
    for (int i = 0; i < N; i++) begin
      cvp = 2'(i); #1;
      chk("R8 gnum", rdata, DW'(i & 8'hFF));
    end
    crd = 0;

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dis = VEC[v][32:29]; en = VEC[v][28:25]; halt = VEC[v][24:21];
      #1;
      chk("R11 busy", DW'(busy), DW'(VEC[v][20:17]));
      @(negedge clk);
      chk("R12 done", DW'(done), DW'(VEC[v][16:13]));
      chk("R2/R3/R4/R5 prev", prev, DW'(VEC[v][12]));
      chk("R2 sleep", DW'(sleep), DW'(VEC[v][11:8]));
      chk("R4 wake", DW'(wake), DW'(VEC[v][7:4]));
      chk("R6 active", DW'(act), DW'(VEC[v][3:0]));
      dis = '0; en = '0; halt = '0;
    end

    // R11 both requests from one VP: disable wins
    @(negedge clk);
    dis = 4'b1000; en = 4'b1000;
    @(negedge clk);
    dis = '0; en = '0;
    chk("R11 dis precedence sleep", DW'(sleep), DW'(4'b0111));
    chk("R11 dis precedence active", DW'(act), DW'(4'b1000));
    // R9 control read and ignored write
    crd = 1; cwr = 1; csel = 0; cvp = 2'd3; #1;
    chk("R9 ctrl read", rdata, 1);
    @(negedge clk); cwr = 0; #1;
    chk("R9 write ignored ctrl", rdata, 1);
    csel = 1; cvp = 2'd2; cwr = 1;
    @(negedge clk); cwr = 0; #1;
    chk("R9 write ignored gnum", rdata, 2);
    crd = 0;
    // R7 has work
    halt = 4'b1001; wpend = 4'b0101; #1;
    chk("R7 has work", DW'(work), DW'(4'b0000));
    halt = 4'b0000; #1;
    chk("R7 active only", DW'(work), DW'(4'b1000));
    halt = 4'b1000; wpend = 4'b1000; #1;
    chk("R7 wake pending", DW'(work), DW'(4'b1000));
    halt = '0; wpend = '0;
    // R10 feature absent
    @(negedge clk);
    present = 0; #1;
    chk("R10 all active", DW'(act), DW'(4'b1111));
    step(4'b0001, 4'b1000, 4'b0000);
    chk("R10 no done", DW'(done), 0);
    crd = 1; csel = 1; cvp = 2'd1; #1;
    chk("R10 unimpl", DW'(unimpl), 1);
    chk("R10 read zero", rdata, 0);
    crd = 0;
    present = 1; #1;
    chk("R10 bits unchanged", DW'(act), DW'(4'b1000));
    step(4'b0000, 4'b1000, 4'b0000);
    @(negedge clk);
    chk("R1 all active again", DW'(act), DW'(4'b1111));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule